// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a 32-pin general-purpose I/O port that software reaches through a simple 32-bit register bus. The bus has an address, a write strobe, a read strobe and separate write and read data. Each pin has three pieces of state: a direction bit, an output latch bit, and a synchronized sample of its pad level. Software can read every register back, except the two aliases described below.

The output latch can be loaded as a whole word. It also has two write-one aliases: one sets the latch bits written as 1, the other clears them. This lets one agent change a single output pin without a read-modify-write that could race with another agent. A direction bit of 1 makes the pin an input with its driver off. A 0 lets the pin drive its latch value onto the pad.

The pad side is three vectors: output data, an active-high driver enable, and input data. Incoming pad levels pass through a two-stage synchronizer before software can see them. A constant revision word sits at offset zero. No other offset decodes.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (all pins input), the output latch reads 0x00000000, `pad_drive_en` is all zero and `bus_rdata` is zero.
- R2: The direction register at byte offset 0x134 is read/write. `pad_drive_en[n]` is the inverse of direction bit n, one clock after the write edge.
- R3: The output latch at offset 0x13C is read/write. A full write replaces all 32 bits, and `pad_out` shows the new value one clock after the write edge.
- R4: A write to offset 0x194 sets each output-latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A write to offset 0x190 clears each output-latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: Offset 0x138 is read-only and returns `pad_in` as it stood two clock edges before the read edge. A write to 0x138 changes no state.
- R7: Offset 0x000 always reads 0x50600801, and a write to it changes no state.
- R8: Offsets 0x190, 0x194 and every unmapped offset read as zero. A write to an unmapped offset changes neither the direction register nor the output latch.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, from register state before any write in that cycle. It holds its value on every edge where `bus_rd` is low.
- R10: `pad_out` always shows the output latch, whatever the direction bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, data appears on `bus_rdata` after the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output latch towards the pads |
| pad_drive_en | output | 32 | Active-high driver enable per pin |

## Verification
The latch is driven with full writes, with set and clear masks that overlap bits already 1 and bits already 0, and with all-zero masks. This separates a correct write-one update from a plain overwrite or an inverted mask. The pad input is changed and read back one edge too early and then again at the right time, which pins down the synchronizer depth. Writes to the read-only, alias and unmapped offsets are each followed by read-back of every stored register, so an aliasing decode shows up. A behavioural model updated on every clock also checks the read path, the driver enables and the output pads throughout the run.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

   // Register byte offsets; software depends on these values.
   localparam int unsigned OFS_REV = 'h000;
   localparam int unsigned OFS_DIR = 'h134;
   localparam int unsigned OFS_IN  = 'h138;
   localparam int unsigned OFS_OUT = 'h13C;
   localparam int unsigned OFS_CLR = 'h190;
   localparam int unsigned OFS_SET = 'h194;

   // Highest offset used, to size the address bus check.
   localparam int unsigned OFS_MAX = OFS_SET;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_REV,
      RSEL_DIR,
      RSEL_IN,
      RSEL_OUT,
      RSEL_CLR,
      RSEL_SET
   } rsel_e;

   // Latch update request decoded from one bus write.
   typedef struct packed {
      logic load;
      logic set;
      logic clr;
   } latch_op_t;

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
   import gpb_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output rsel_e             sel
);

   generate
      if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr
         $error("gpb_decode: ADDR_W must hold offset 0x%0h and be at most 32", OFS_MAX);
      end
   endgenerate

   always_comb begin
      sel = RSEL_NONE;
      if      (addr == ADDR_W'(OFS_REV)) sel = RSEL_REV;
      else if (addr == ADDR_W'(OFS_DIR)) sel = RSEL_DIR;
      else if (addr == ADDR_W'(OFS_IN))  sel = RSEL_IN;
      else if (addr == ADDR_W'(OFS_OUT)) sel = RSEL_OUT;
      else if (addr == ADDR_W'(OFS_CLR)) sel = RSEL_CLR;
      else if (addr == ADDR_W'(OFS_SET)) sel = RSEL_SET;
   end

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpb_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gpb_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpb_outreg.sv
module gpb_outreg
   import gpb_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  latch_op_t        op,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = q;
      if (op.load) nxt = wdata;
      if (op.set)  nxt = nxt | wdata;
      if (op.clr)  nxt = nxt & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R4: bits written as one through the set alias end up high
   p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op.set && !op.clr && !op.load) |=> ((q & $past(wdata)) == $past(wdata)));

   // R4: bits written as zero through the set alias keep their value
   p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op.set && !op.clr && !op.load) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

   // R5: bits written as one through the clear alias end up low
   p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op.clr && !op.set && !op.load) |=> ((q & $past(wdata)) == '0));

   // R5: bits written as zero through the clear alias keep their value
   p_clr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op.clr && !op.set && !op.load) |=> ((q | $past(wdata)) == ($past(q) | $past(wdata))));

   // R3: with no update request the latch holds
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!op.load && !op.set && !op.clr) |=> $stable(q));

   // R3: a full write replaces the latch
   p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op.load && !op.set && !op.clr) |=> (q == $past(wdata)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpb_pkg::*;
#(
   parameter int          NPINS       = 32,
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] REV_VALUE   = 32'h5060_0801
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_drive_en
);

   localparam logic [NPINS-1:0] DIR_RESET = {NPINS{1'b1}};

   generate
      if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_pins
         $error("gpio_port_regs: NPINS must be between 1 and DATA_W");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("gpio_port_regs: DATA_W must be 32");
      end
   endgenerate

   rsel_e            sel;
   latch_op_t        lop;
   logic [NPINS-1:0] wpins;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] out_q;
   logic [NPINS-1:0] in_sync;
   logic [DATA_W-1:0] rd_mux;

   assign wpins = bus_wdata[NPINS-1:0];

   gpb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (in_sync)
   );

   always_comb begin
      lop.load = bus_wr && (sel == RSEL_OUT);
      lop.set  = bus_wr && (sel == RSEL_SET);
      lop.clr  = bus_wr && (sel == RSEL_CLR);
   end

   gpb_outreg #(.WIDTH(NPINS)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (lop),
      .wdata (wpins),
      .q     (out_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             dir_q <= DIR_RESET;
      else if (bus_wr && (sel == RSEL_DIR))   dir_q <= wpins;
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         RSEL_REV: rd_mux = DATA_W'(REV_VALUE);
         RSEL_DIR: rd_mux = DATA_W'(dir_q);
         RSEL_IN:  rd_mux = DATA_W'(in_sync);
         RSEL_OUT: rd_mux = DATA_W'(out_q);
         RSEL_CLR, RSEL_SET, RSEL_NONE: rd_mux = '0;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign pad_out      = out_q;
   assign pad_drive_en = ~dir_q;

   // R2: a direction write shows at the driver enables on the next cycle
   p_dir_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (pad_drive_en == ~$past(wpins)));

   // R7: the revision word reads as its constant
   p_rev_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_REV)) |=> (bus_rdata == DATA_W'(REV_VALUE)));

   // R8: aliases read as zero
   p_alias_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR)))
      |=> (bus_rdata == '0));

   // R8: a write outside the direction offset leaves the direction alone
   p_dir_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && bus_addr == ADDR_W'(OFS_DIR))) |=> $stable(pad_drive_en));

   // R9: read data holds when no read is issued
   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd) |=> $stable(bus_rdata));

   // R10: the pads follow the latch read back through the bus
   p_pad_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_OUT) && !bus_wr) |=> (bus_rdata == DATA_W'(pad_out)));

endmodule

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_drive_en;

   int total = 0;
   int bad = 0;
   bit model_on = 1'b0;
   bit finished = 1'b0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   gpio_port_regs uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pad_in       (pad_in),
      .pad_out      (pad_out),
      .pad_drive_en (pad_drive_en)
   );

   // behavioural reference model
   logic [31:0] m_dir = 32'hFFFF_FFFF;
   logic [31:0] m_out = '0;
   logic [31:0] m_rdata = '0;
   logic [31:0] m_pipe [$] = '{32'h0, 32'h0};

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h000: return 32'h5060_0801;
         12'h134: return m_dir;
         12'h138: return m_pipe[0];
         12'h13C: return m_out;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir = 32'hFFFF_FFFF;
         m_out = '0;
         m_rdata = '0;
         m_pipe = '{32'h0, 32'h0};
      end else begin
         if (bus_rd) m_rdata = m_read(bus_addr);
         if (bus_wr) begin
            case (bus_addr)
               12'h134: m_dir = bus_wdata;
               12'h13C: m_out = bus_wdata;
               12'h194: m_out = m_out | bus_wdata;
               12'h190: m_out = m_out & ~bus_wdata;
               default: ;
            endcase
         end
         void'(m_pipe.pop_front());
         m_pipe.push_back(pad_in);
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (model_on && rst_n) begin
         check("R9 read path", bus_rdata, m_rdata);
         check("R3 pad_out", pad_out, m_out);
         check("R2 pad_drive_en", pad_drive_en, ~m_dir);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, bus_rdata, exp);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected<20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during and right after reset
      check("R1 drive_en in reset", pad_drive_en, 32'h0);
      check("R1 pad_out in reset", pad_out, 32'h0);
      rst_n = 1'b1;
      model_on = 1'b1;
      check("R1 rdata after reset", bus_rdata, 32'h0);
      rd(12'h134, 32'hFFFF_FFFF, "R1 dir reset");
      rd(12'h13C, 32'h0, "R1 latch reset");

      // R7: revision constant, write ignored
      rd(12'h000, 32'h5060_0801, "R7 revision");
      wr(12'h000, 32'h0000_0000);
      rd(12'h000, 32'h5060_0801, "R7 revision after write");
      rd(12'h13C, 32'h0, "R7 write left latch");

      // R3 / R10: full latch write while all pins are inputs
      wr(12'h13C, 32'hA5A5_0F0F);
      check("R10 pad_out while input", pad_out, 32'hA5A5_0F0F);
      rd(12'h13C, 32'hA5A5_0F0F, "R3 latch readback");

      // R4: set alias, including a mask overlapping ones
      wr(12'h194, 32'h0000_00F3);
      rd(12'h13C, 32'hA5A5_0FFF, "R4 set alias");
      wr(12'h194, 32'h0);
      rd(12'h13C, 32'hA5A5_0FFF, "R4 zero mask");

      // R5: clear alias, including bits already zero
      wr(12'h190, 32'hA000_500F);
      rd(12'h13C, 32'h05A5_0FF0, "R5 clear alias");
      wr(12'h190, 32'h0);
      rd(12'h13C, 32'h05A5_0FF0, "R5 zero mask");

      // R2: direction and driver enables
      wr(12'h134, 32'h0000_FFFF);
      check("R2 drive_en after dir write", pad_drive_en, 32'hFFFF_0000);
      rd(12'h134, 32'h0000_FFFF, "R2 dir readback");
      check("R10 pad_out with outputs", pad_out, 32'h05A5_0FF0);

      // R6: synchronizer depth
      @(negedge clk);
      pad_in = 32'h1234_5678;
      rd(12'h138, 32'h0, "R6 early read");
      rd(12'h138, 32'h1234_5678, "R6 synced read");
      wr(12'h138, 32'hFFFF_FFFF);
      rd(12'h138, 32'h1234_5678, "R6 write ignored");
      rd(12'h13C, 32'h05A5_0FF0, "R6 latch untouched");
      rd(12'h134, 32'h0000_FFFF, "R6 dir untouched");

      // R8: aliases and unmapped offsets
      rd(12'h190, 32'h0, "R8 clear alias reads zero");
      rd(12'h194, 32'h0, "R8 set alias reads zero");
      rd(12'h100, 32'h0, "R8 unmapped read");
      wr(12'h100, 32'hDEAD_BEEF);
      wr(12'h136, 32'hDEAD_BEEF);
      rd(12'h134, 32'h0000_FFFF, "R8 dir after unmapped write");
      rd(12'h13C, 32'h05A5_0FF0, "R8 latch after unmapped write");

      // R9: read data holds with no read, and read sees pre-write value
      repeat (3) @(negedge clk);
      check("R9 hold", bus_rdata, 32'h05A5_0FF0);
      @(negedge clk);
      bus_addr = 12'h13C; bus_wdata = 32'h0000_0001; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R9 read before write", bus_rdata, 32'h05A5_0FF0);
      rd(12'h13C, 32'h0000_0001, "R9 write landed");

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule